// File: doc/BRIEF.md
# Centre-Aligned Up/Down PWM Timer

This block is an up/down timer with a single pulse-width output. Its counter climbs from zero to a ceiling and then falls back to zero, over and over. Each value appears for one advance, so one full period lasts twice the ceiling in advances. The ceiling is either the full count range or a value held in compare slot A. The count is compared with compare slot B, and the result drives the waveform pin. The pin goes one way on a match while the count is rising and the other way on a match while it is falling. This gives a pulse centred in each period. A polarity field selects the plain or the inverted waveform, or holds the pin low.

The counter advances only on cycles where the enable tick is high. Software-side writes land in holding registers. These are copied into the working compare slots only at the moment the counter turns at its ceiling, so a period never sees a half-changed setting. Two sticky flags report that the counter reached zero and that the count equalled compare slot B. Each flag is cleared by its own pulse input.

All pins are plain control and status signals. No stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `pwm_dual_slope`

## Requirements
- R1: On each cycle with `tick_i` high, the count moves by one. It rises from 0 to the ceiling and falls from the ceiling to 0. The ceiling value and 0 are each shown for one advance, so a period is 2×ceiling advances. On cycles with `tick_i` low, the count, direction and waveform level hold.
- R2: The ceiling is 2^W−1 (255 by default) when `top_sel_i`=0 and the working slot A when `top_sel_i`=1. If the count lies above the ceiling while rising, it turns downward at the next advance. A ceiling of 0 keeps the count at 0.
- R3: With `out_mode_i`=2, a tick edge at which the pre-edge count equals working slot B sets the waveform level. It is set to 0 if the counter is in its rising phase and to 1 if it is in its falling phase. The rising phase runs from leaving 0 up to and including the ceiling, and also covers the count of 0 straight after reset. The falling phase runs below the ceiling down to and including 0. `wave_o` shows the level from the cycle after that edge.
- R4: With `out_mode_i`=3, `wave_o` is the inverse of the level defined in R3.
- R5: With `out_mode_i`=0 or 1, `wave_o` is 0. The level keeps tracking in the background, and it reappears as soon as the mode returns to 2 or 3.
- R6: `ovf_flag_o` goes to 1 after a tick edge at which the count moves from a non-zero value to 0. It stays at 1 until a cycle with `ovf_clr_i` high clears it. A set on the same edge takes priority over a clear.
- R7: `wr_a_i`/`wr_b_i` load `wr_data_i` into the holding register for slot A or B. The holding values are copied to the working slots only on the tick edge where the rising count meets or exceeds the ceiling. A write on that same edge lands in the holding register, and the working slot receives the older holding value.
- R8: `cmp_flag_o` goes to 1 after any tick edge at which the pre-edge count equals working slot B, in either phase. It stays at 1 until `cmp_clr_i` clears it, and a set takes priority over a clear.
- R9: After reset, the count is 0 in the rising phase. Both flags, all four compare registers and the waveform level are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Advance enable for the counter |
| top_sel_i | input | 1 | 0: full-range ceiling, 1: ceiling from working slot A |
| out_mode_i | input | 2 | 0/1 pin low, 2 plain, 3 inverted |
| wr_a_i | input | 1 | Load holding register A |
| wr_b_i | input | 1 | Load holding register B |
| wr_data_i | input | W | Value for a holding register write |
| ovf_clr_i | input | 1 | Clear the zero-reached flag |
| cmp_clr_i | input | 1 | Clear the compare-match flag |
| wave_o | output | 1 | Waveform pin |
| count_o | output | W | Current count |
| ovf_flag_o | output | 1 | Sticky zero-reached flag |
| cmp_flag_o | output | 1 | Sticky compare-match flag |

## Verification
The hardest case to reach is a holding-register write that coincides exactly with the turn at the ceiling. On that edge the working slot must take the older value while the holding register takes the new one. The stimulus watches `count_o` until it shows the ceiling with the tick held high, so the next edge is known to be the turn, and it issues the write in that cycle. A second hard case is a working ceiling of 0, which leaves the counter turning on every advance. The stimulus reaches it by loading 0 into slot A and then shows that the counter leaves it once a non-zero value is loaded. A scoreboard fed by a predictor compares every cycle, and the flag clears are pulsed while matches keep occurring.

// File: rtl/pwm_ds_pkg.sv
package pwm_ds_pkg;

  typedef enum logic [1:0] {
    PM_OFF0  = 2'd0,
    PM_OFF1  = 2'd1,
    PM_PLAIN = 2'd2,
    PM_INV   = 2'd3
  } pwm_mode_e;

  localparam int unsigned N_SLOTS = 2;
  localparam int unsigned SLOT_A  = 0;
  localparam int unsigned SLOT_B  = 1;

endpackage

// File: rtl/pwm_cmp_buffer.sv
module pwm_cmp_buffer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_a_i,
  input  logic         wr_b_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         upd_i,
  output logic [W-1:0] act_a_o,
  output logic [W-1:0] act_b_o
);
  import pwm_ds_pkg::*;

  logic [N_SLOTS-1:0] wr_vec;
  logic [W-1:0]       hold_q [N_SLOTS];
  logic [W-1:0]       act_q  [N_SLOTS];

  assign wr_vec = {wr_b_i, wr_a_i};

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hold_q[g] <= '0;
        act_q[g]  <= '0;
      end else begin
        if (wr_vec[g]) hold_q[g] <= wr_data_i;
        if (upd_i)     act_q[g]  <= hold_q[g];
      end
    end

    // R7: working slot only moves on an update edge
    a_r7_hold_between_updates: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_i |=> $stable(act_q[g]));
  end

  assign act_a_o = act_q[SLOT_A];
  assign act_b_o = act_q[SLOT_B];

  // R7: a copy takes the holding value from before the edge
  a_r7_copy_old_hold: assert property (@(posedge clk) disable iff (!rst_n)
    upd_i |=> act_b_o == $past(hold_q[SLOT_B]));

endmodule

// File: rtl/pwm_updown_counter.sv
module pwm_updown_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic [W-1:0] top_i,
  output logic [W-1:0] cnt_o,
  output logic         up_o,
  output logic         turn_top_o,
  output logic         bottom_hit_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         up_q, up_d;

  always_comb begin
    cnt_d      = cnt_q;
    up_d       = up_q;
    turn_top_o = 1'b0;
    if (tick_i) begin
      if (up_q) begin
        if (cnt_q >= top_i) begin
          turn_top_o = 1'b1;
          up_d       = 1'b0;
          cnt_d      = (cnt_q == '0) ? '0 : cnt_q - ONE;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end else begin
        if (cnt_q == '0) begin
          up_d  = 1'b1;
          cnt_d = (top_i == '0) ? '0 : ONE;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
    end
  end

  assign bottom_hit_o = tick_i && (cnt_d == '0) && (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end

  assign cnt_o = cnt_q;
  assign up_o  = up_q;

  // R1: nothing moves without a tick
  a_r1_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cnt_q) && $stable(up_q));

  // R1: every advance is a unit step or a stay at zero
  a_r1_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> (cnt_q == $past(cnt_q) + ONE) || (cnt_q == $past(cnt_q) - ONE) ||
               (cnt_q == '0 && $past(cnt_q) == '0));

  // R2: a zero ceiling pins the count at zero
  a_r2_zero_top: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && top_i == '0 && cnt_q == '0) |=> cnt_q == '0);

endmodule

// File: rtl/pwm_wave_out.sv
module pwm_wave_out #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic [W-1:0] cnt_i,
  input  logic         up_i,
  input  logic [W-1:0] cmp_i,
  input  logic [1:0]   mode_i,
  output logic         match_o,
  output logic         wave_o
);
  import pwm_ds_pkg::*;

  pwm_mode_e mode;
  logic      lvl_q;

  assign mode    = pwm_mode_e'(mode_i);
  assign match_o = tick_i && (cnt_i == cmp_i);

  always_ff @(posedge clk) begin
    if (!rst_n)       lvl_q <= 1'b0;
    else if (match_o) lvl_q <= !up_i;
  end

  always_comb begin
    unique case (mode)
      PM_PLAIN: wave_o = lvl_q;
      PM_INV:   wave_o = !lvl_q;
      default:  wave_o = 1'b0;
    endcase
  end

  // R3: rising-phase match clears the level
  a_r3_clear_rising: assert property (@(posedge clk) disable iff (!rst_n)
    (match_o && up_i) |=> !lvl_q);

  // R3: falling-phase match sets the level
  a_r3_set_falling: assert property (@(posedge clk) disable iff (!rst_n)
    (match_o && !up_i) |=> lvl_q);

  // R5: disconnected modes keep the pin low
  a_r5_pin_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i[1] == 1'b0) |-> !wave_o);

endmodule

// File: rtl/pwm_sticky_flag.sv
module pwm_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  // R6 and R8: a set wins over a simultaneous clear
  a_r6_set_priority: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);

  // R8: flag is sticky until cleared
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_i) |=> flag_o);

endmodule

// File: rtl/pwm_dual_slope.sv
module pwm_dual_slope #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         top_sel_i,
  input  logic [1:0]   out_mode_i,
  input  logic         wr_a_i,
  input  logic         wr_b_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         ovf_clr_i,
  input  logic         cmp_clr_i,
  output logic         wave_o,
  output logic [W-1:0] count_o,
  output logic         ovf_flag_o,
  output logic         cmp_flag_o
);
  localparam logic [W-1:0] FULL_TOP = {W{1'b1}};
  localparam int unsigned  N_FLAGS  = 2;

  logic [W-1:0] act_a, act_b, top;
  logic [W-1:0] cnt;
  logic         up, turn_top, bottom_hit, match;
  logic [N_FLAGS-1:0] flag_set, flag_clr, flag_q;

  assign top = top_sel_i ? act_a : FULL_TOP;

  pwm_cmp_buffer #(.W(W)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .wr_a_i(wr_a_i), .wr_b_i(wr_b_i), .wr_data_i(wr_data_i),
    .upd_i(turn_top), .act_a_o(act_a), .act_b_o(act_b)
  );

  pwm_updown_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .top_i(top),
    .cnt_o(cnt), .up_o(up), .turn_top_o(turn_top), .bottom_hit_o(bottom_hit)
  );

  pwm_wave_out #(.W(W)) u_wave (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cnt_i(cnt), .up_i(up),
    .cmp_i(act_b), .mode_i(out_mode_i), .match_o(match), .wave_o(wave_o)
  );

  assign flag_set = {match, bottom_hit};
  assign flag_clr = {cmp_clr_i, ovf_clr_i};

  for (genvar f = 0; f < N_FLAGS; f++) begin : g_flag
    pwm_sticky_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set_i(flag_set[f]), .clr_i(flag_clr[f]),
      .flag_o(flag_q[f])
    );
  end

  assign count_o    = cnt;
  assign ovf_flag_o = flag_q[0];
  assign cmp_flag_o = flag_q[1];

  // R6: a fresh zero-reached flag coincides with a count of zero
  a_r6_rise_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag_o) |-> count_o == '0);

  // R1: the count never leaves its range around a full-range ceiling
  a_r1_turn_goes_down: assert property (@(posedge clk) disable iff (!rst_n)
    (turn_top && count_o != '0) |=> count_o == $past(count_o) - W'(1));

endmodule

// File: tb/tb_pwm_dual_slope.sv
module tb_pwm_dual_slope;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick_i = 1'b0;
  logic         top_sel_i = 1'b0;
  logic [1:0]   out_mode_i = 2'd0;
  logic         wr_a_i = 1'b0;
  logic         wr_b_i = 1'b0;
  logic [W-1:0] wr_data_i = '0;
  logic         ovf_clr_i = 1'b0;
  logic         cmp_clr_i = 1'b0;
  logic         wave_o;
  logic [W-1:0] count_o;
  logic         ovf_flag_o;
  logic         cmp_flag_o;

  always #4 clk = ~clk;

  pwm_dual_slope #(.W(W)) dut (.*);

  typedef struct packed {
    logic [W-1:0] cnt;
    logic         lvl;
    logic         ovf;
    logic         cmp;
  } exp_t;

  exp_t exp_q[$];
  int   vectors = 0;
  int   miscompares = 0;
  bit   done = 1'b0;

  // Predictor: builds expected state from the requirements each clock edge
  int   m_cnt, m_hold_a, m_hold_b, m_act_a, m_act_b;
  bit   m_rising, m_lvl, m_ovf, m_cmp;

  always @(posedge clk) begin
    int ceil_v, nxt;
    bit hit, turn;
    if (!rst_n) begin
      // R9 reset values
      m_cnt = 0; m_rising = 1; m_lvl = 0; m_ovf = 0; m_cmp = 0;
      m_hold_a = 0; m_hold_b = 0; m_act_a = 0; m_act_b = 0;
    end else begin
      hit = 0; turn = 0; nxt = m_cnt;
      if (tick_i) begin
        ceil_v = top_sel_i ? m_act_a : 255;
        hit = (m_cnt == m_act_b);
        if (hit) m_lvl = !m_rising;
        if (m_rising && m_cnt >= ceil_v) begin
          turn = 1; m_rising = 0;
          nxt = (m_cnt == 0) ? 0 : m_cnt - 1;
        end else if (m_rising) begin
          nxt = m_cnt + 1;
        end else if (m_cnt == 0) begin
          m_rising = 1;
          nxt = (ceil_v == 0) ? 0 : 1;
        end else begin
          nxt = m_cnt - 1;
        end
        if (nxt == 0 && m_cnt != 0) m_ovf = 1;
        else if (ovf_clr_i) m_ovf = 0;
        if (hit) m_cmp = 1;
        else if (cmp_clr_i) m_cmp = 0;
        if (turn) begin m_act_a = m_hold_a; m_act_b = m_hold_b; end
        m_cnt = nxt;
      end else begin
        if (ovf_clr_i) m_ovf = 0;
        if (cmp_clr_i) m_cmp = 0;
      end
      if (wr_a_i) m_hold_a = wr_data_i;
      if (wr_b_i) m_hold_b = wr_data_i;
    end
    exp_q.push_back('{cnt: m_cnt[W-1:0], lvl: m_lvl, ovf: m_ovf, cmp: m_cmp});
  end

  // Monitor: pops one expected item per cycle and compares at the falling edge
  always @(negedge clk) begin
    exp_t e;
    logic ew;
    if (exp_q.size() != 0 && !done) begin
      e = exp_q.pop_front();
      ew = (out_mode_i == 2'd2) ? e.lvl : (out_mode_i == 2'd3) ? !e.lvl : 1'b0;
      vectors++;
      if (count_o !== e.cnt) begin
        miscompares++;
        $display("FAIL R1 R2 R7 count: got %0d exp %0d at %0t", count_o, e.cnt, $time);
      end
      if (wave_o !== ew) begin
        miscompares++;
        $display("FAIL R3 R4 R5 wave (mode %0d): got %0b exp %0b at %0t",
                 out_mode_i, wave_o, ew, $time);
      end
      if (ovf_flag_o !== e.ovf) begin
        miscompares++;
        $display("FAIL R6 ovf flag: got %0b exp %0b at %0t", ovf_flag_o, e.ovf, $time);
      end
      if (cmp_flag_o !== e.cmp) begin
        miscompares++;
        $display("FAIL R8 cmp flag: got %0b exp %0b at %0t", cmp_flag_o, e.cmp, $time);
      end
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic write_slot(input bit to_a, input int v);
    wr_data_i = v[W-1:0];
    if (to_a) wr_a_i = 1'b1; else wr_b_i = 1'b1;
    cyc(1);
    wr_a_i = 1'b0; wr_b_i = 1'b0;
  endtask

  task automatic wait_count(input int v);
    int guard = 0;
    while (count_o != v[W-1:0] && guard < 2000) begin
      cyc(1);
      guard++;
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got timeout exp completion");
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    cyc(3);
    // R9: reset state seen directly at the ports
    vectors++;
    if (count_o !== '0 || ovf_flag_o !== 1'b0 || cmp_flag_o !== 1'b0 || wave_o !== 1'b0) begin
      miscompares++;
      $display("FAIL R9 reset: got cnt %0d ovf %0b cmp %0b wave %0b exp 0 0 0 0",
               count_o, ovf_flag_o, cmp_flag_o, wave_o);
    end
    rst_n = 1'b1;

    // R1 R3: full-range ceiling, plain output, B = 100 taken at first turn
    out_mode_i = 2'd2;
    tick_i = 1'b1;
    write_slot(0, 100);
    cyc(1200);

    // R1: sparse ticks hold everything between advances
    for (int i = 0; i < 700; i++) begin
      tick_i = (i % 3 == 0);
      cyc(1);
    end
    tick_i = 1'b1;

    // R2 R4: ceiling from slot A, inverted output, with clears pulsed (R6 R8)
    write_slot(1, 20);
    write_slot(0, 7);
    out_mode_i = 2'd3;
    top_sel_i = 1'b1;
    for (int i = 0; i < 300; i++) begin
      ovf_clr_i = (i % 7 == 0);
      cmp_clr_i = (i % 5 == 0);
      cyc(1);
    end
    ovf_clr_i = 1'b0; cmp_clr_i = 1'b0;

    // R7: write landing on the exact turn edge
    wait_count(20);
    wr_data_i = 8'd12; wr_a_i = 1'b1; wr_b_i = 1'b1;
    cyc(1);
    wr_a_i = 1'b0; wr_b_i = 1'b0;
    cyc(200);

    // R5: disconnected modes, then back to plain
    out_mode_i = 2'd1; cyc(60);
    out_mode_i = 2'd0; cyc(60);
    out_mode_i = 2'd2; cyc(60);

    // R3: compare value at zero
    write_slot(0, 0);
    cyc(200);

    // R2: zero ceiling pins the counter, then recovery
    write_slot(1, 0);
    cyc(120);
    write_slot(1, 5);
    write_slot(0, 3);
    cyc(150);

    // R6 R8: clear held steady while matches continue
    ovf_clr_i = 1'b1; cmp_clr_i = 1'b1;
    cyc(40);
    ovf_clr_i = 1'b0; cmp_clr_i = 1'b0;

    // R2: switch back to full range mid-period
    top_sel_i = 1'b0;
    write_slot(0, 200);
    cyc(800);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule